// File: doc/BRIEF.md
# Bit-Banged Serial Line Port

This block is one fully decoded I/O register that lets software drive a serial transmit line and an outgoing handshake line bit by bit, and sample the receive line and an incoming handshake line. It sits on an 8-bit processor bus: a 16-bit I/O address, write and read data buses, and active-low strobes for I/O request, read and write. A configuration switch enables the port. A jumper picks which of two incoming handshake lines is reported, so the same port can serve a computer link or a serial printer.

Data travels inverted in both directions. The port therefore applies no inversion of its own. The line level that software writes into bit 0 goes straight to the transmit pin. The receive pin level comes back in bit 7. In both cases 0 is the idle level, and software complements the bytes itself. Bit 0 of a read acts as a presence flag: it reads 0 only while the port is switched on. When the port is not selected, the data bus is not driven and reads as all ones. The incoming lines are asynchronous and pass through a two-flop synchroniser before a read can see them.

The bus has no valid/ready stream. Every access completes in the cycle its strobes are active and can never be held off, so the block has no back-pressure rules. All pins are plain control and status signals.

Top module: `bitbang_serial_port`

## Requirements
- R1: The port answers only at I/O address 16'hFEEF with `iorq_n` low. An access at any other address, or with `iorq_n` high, leaves both outputs unchanged and does not drive the data bus.
- R2: A write (port on, address matched, `iorq_n` and `wr_n` low) loads `wdata[1]` into `hs_out` and `wdata[0]` into `line_tx`. Both are visible after the clock edge at which the write is sampled. Bits 7..2 of the written byte have no effect.
- R3: Between writes, `line_tx` and `hs_out` hold their values.
- R4: A read returns the synchronised receive line in bit 7, the synchronised selected handshake line in bit 6, ones in bits 5..1, and 0 in bit 0 (port present and enabled).
- R5: `rdata_oe` is high exactly while the port is on, the address matches, and `iorq_n` and `rd_n` are low. Whenever `rdata_oe` is low, `rdata` reads 8'hFF.
- R6: At every clock edge where `port_on` is low, both outputs return to 0 (idle), writes are ignored, and reads are not answered. After the switch comes back on, the outputs stay 0 until the next write.
- R7: An active-low `rst_n` clears `line_tx`, `hs_out` and the synchroniser at once, without waiting for a clock edge.
- R8: With `hs_pick` at 0, bit 6 reports `hs_in_link`. With `hs_pick` at 1, it reports `hs_in_prn`.
- R9: A change on `line_rx`, `hs_in_link` or `hs_in_prn` that is set up before clock edge k appears on reads after edge k+1, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | I/O address |
| wdata | input | 8 | Data written by the processor |
| rdata | output | 8 | Data returned on a read, 8'hFF when not driven |
| rdata_oe | output | 1 | High while the port drives the data bus |
| iorq_n | input | 1 | Active-low I/O request |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| port_on | input | 1 | Configuration switch, 1 enables the port |
| line_rx | input | 1 | Incoming serial line (inverted data, 0 idle) |
| hs_in_link | input | 1 | Incoming handshake from a computer link |
| hs_in_prn | input | 1 | Incoming handshake from a printer |
| hs_pick | input | 1 | Jumper: 0 selects hs_in_link, 1 selects hs_in_prn |
| line_tx | output | 1 | Outgoing serial line (inverted data, 0 idle) |
| hs_out | output | 1 | Outgoing handshake, 1 means ok to send |

## Verification
The bound checker watches several rules on every cycle. These are the write-to-output load, the hold between writes, the idle forcing while the switch is off or reset is low, the fixed bits and presence flag of a read, the undriven bus value, and the two-edge latency of each input line through to the read data, including the jumper choice. Full address decoding against near-miss addresses needs the bench's scenarios to show it. So does the behaviour after the switch returns: outputs stay idle until software writes again. So do asynchronous reset taking effect between edges and an input change that is still hidden one edge after it happens. The bench also compares every output against its reference model at every clock.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } sp_access_e;

  localparam int WR_TX_BIT = 0;
  localparam int WR_HS_BIT = 1;
  localparam int SYNC_W    = 3;
  localparam int SYNC_RX   = 2;
  localparam int SYNC_PRN  = 1;
  localparam int SYNC_LINK = 0;
endpackage

// File: rtl/sp_decode.sv
module sp_decode
  import sp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hFEEF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              enable,
  output sp_access_e        access
);
  logic hit;

  always_comb begin
    hit = enable && !iorq_n && (addr == PORT_ADDR);
    access = ACC_IDLE;
    if (hit && !rd_n)      access = ACC_READ;
    else if (hit && !wr_n) access = ACC_WRITE;
  end
endmodule

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sp_line_reg.sv
module sp_line_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic load,
  input  logic tx_d,
  input  logic hs_d,
  output logic tx_q,
  output logic hs_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= 1'b0;
      hs_q <= 1'b0;
    end else if (!enable) begin
      tx_q <= 1'b0;
      hs_q <= 1'b0;
    end else if (load) begin
      tx_q <= tx_d;
      hs_q <= hs_d;
    end
  end
endmodule

// File: rtl/bitbang_serial_port.sv
module bitbang_serial_port
  import sp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hFEEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              port_on,
  input  logic              line_rx,
  input  logic              hs_in_link,
  input  logic              hs_in_prn,
  input  logic              hs_pick,
  output logic              line_tx,
  output logic              hs_out
);
  localparam int RD_RX_BIT = DATA_W - 1;
  localparam int RD_HS_BIT = DATA_W - 2;

  sp_access_e        access;
  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] sync_in;
  logic              hs_chosen;
  logic              wdata_unused;

  assign wdata_unused = ^wdata[DATA_W-1:WR_HS_BIT+1];

  sp_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr(addr), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .enable(port_on), .access(access)
  );

  always_comb begin
    raw_in = '0;
    raw_in[SYNC_RX]   = line_rx;
    raw_in[SYNC_PRN]  = hs_in_prn;
    raw_in[SYNC_LINK] = hs_in_link;
  end

  sp_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_in)
  );

  sp_line_reg u_lines (
    .clk(clk), .rst_n(rst_n), .enable(port_on),
    .load(access == ACC_WRITE),
    .tx_d(wdata[WR_TX_BIT]), .hs_d(wdata[WR_HS_BIT]),
    .tx_q(line_tx), .hs_q(hs_out)
  );

  assign hs_chosen = hs_pick ? sync_in[SYNC_PRN] : sync_in[SYNC_LINK];
  assign rdata_oe  = (access == ACC_READ);

  always_comb begin
    rdata = '1;
    if (rdata_oe) begin
      rdata[RD_RX_BIT] = sync_in[SYNC_RX];
      rdata[RD_HS_BIT] = hs_chosen;
      rdata[0]         = 1'b0;
    end
  end
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hFEEF,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_oe,
  input logic              iorq_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              port_on,
  input logic              line_rx,
  input logic              hs_in_link,
  input logic              hs_in_prn,
  input logic              hs_pick,
  input logic              line_tx,
  input logic              hs_out
);
  logic wr_hit;
  logic [2:0] hist [SYNC_STAGES];
  logic [7:0] since_rst;
  logic       warm;

  assign wr_hit = port_on && !iorq_n && rd_n && !wr_n && (addr == PORT_ADDR);
  assign warm   = (since_rst >= 8'(SYNC_STAGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (!warm) since_rst <= since_rst + 8'd1;
  end

  always_ff @(posedge clk) begin
    hist[0] <= {line_rx, hs_in_prn, hs_in_link};
    for (int i = 1; i < SYNC_STAGES; i++) hist[i] <= hist[i-1];
  end

  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (line_tx == $past(wdata[0])) && (hs_out == $past(wdata[1])));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (port_on && !wr_hit) |=> $stable(line_tx) && $stable(hs_out));

  a_r6_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !port_on |=> !line_tx && !hs_out && !rdata_oe);

  a_r7_reset_idle: assert property (@(posedge clk)
    !rst_n |-> !line_tx && !hs_out);

  a_r5_undriven_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> rdata == '1);

  a_r4_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (rdata[DATA_W-3:1] == '1) && !rdata[0] && port_on);

  a_r9_rx_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && warm) |-> rdata[DATA_W-1] == hist[SYNC_STAGES-1][2]);

  a_r8_jumper_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && warm) |-> rdata[DATA_W-2] ==
      (hs_pick ? hist[SYNC_STAGES-1][1] : hist[SYNC_STAGES-1][0]));
endmodule

bind bitbang_serial_port sp_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rdata(rdata),
  .rdata_oe(rdata_oe), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
  .port_on(port_on), .line_rx(line_rx), .hs_in_link(hs_in_link),
  .hs_in_prn(hs_in_prn), .hs_pick(hs_pick), .line_tx(line_tx), .hs_out(hs_out)
);

// File: tb/sim_bitbang_serial_port.sv
module sim_bitbang_serial_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        rdata_oe;
  logic        iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic        port_on = 1'b1;
  logic        line_rx = 1'b0, hs_in_link = 1'b0, hs_in_prn = 1'b0, hs_pick = 1'b0;
  logic        line_tx, hs_out;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  bitbang_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .port_on(port_on), .line_rx(line_rx), .hs_in_link(hs_in_link),
    .hs_in_prn(hs_in_prn), .hs_pick(hs_pick), .line_tx(line_tx), .hs_out(hs_out)
  );

  always #10 clk = ~clk;

  // Behavioural reference model
  bit m_tx, m_hs;
  bit q_rx[$], q_link[$], q_prn[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tx = 0; m_hs = 0;
      q_rx.delete(); q_link.delete(); q_prn.delete();
    end else begin
      q_rx.push_back(line_rx); q_link.push_back(hs_in_link); q_prn.push_back(hs_in_prn);
      if (q_rx.size() > 2) begin
        void'(q_rx.pop_front()); void'(q_link.pop_front()); void'(q_prn.pop_front());
      end
      if (!port_on) begin
        m_tx = 0; m_hs = 0;
      end else if (addr == 16'hFEEF && !iorq_n && rd_n && !wr_n) begin
        m_tx = wdata[0]; m_hs = wdata[1];
      end
    end
  end

  function automatic logic [7:0] exp_rdata();
    bit rx, hs;
    if (!(port_on && addr == 16'hFEEF && !iorq_n && !rd_n)) return 8'hFF;
    rx = (q_rx.size() == 2) ? q_rx[0] : 1'b0;
    hs = (q_rx.size() == 2) ? (hs_pick ? q_prn[0] : q_link[0]) : 1'b0;
    return {rx, hs, 5'b11111, 1'b0};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (!done) begin
      check("R2 line_tx model", {7'd0, line_tx}, {7'd0, m_tx});
      check("R3 hs_out model", {7'd0, hs_out}, {7'd0, m_hs});
      check("R5 rdata_oe model", {7'd0, rdata_oe},
            {7'd0, port_on && addr == 16'hFEEF && !iorq_n && !rd_n});
      check("R4 rdata model", rdata, exp_rdata());
    end
  end

  task automatic bus_write(logic [15:0] a, logic [7:0] d, logic rq = 1'b0);
    @(negedge clk);
    addr = a; wdata = d; iorq_n = rq; wr_n = 1'b0;
    @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1; addr = 16'h0000;
    #3;
  endtask

  task automatic start_read(logic [15:0] a);
    @(negedge clk);
    addr = a; iorq_n = 1'b0; rd_n = 1'b0;
    #3;
  endtask

  task automatic end_read();
    @(negedge clk);
    iorq_n = 1'b1; rd_n = 1'b1; addr = 16'h0000;
  endtask

  task automatic wait_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #3;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    // R7: reset state
    wait_cycles(3);
    check("R7 tx in reset", {7'd0, line_tx}, 8'd0);
    check("R7 hs in reset", {7'd0, hs_out}, 8'd0);
    rst_n = 1'b1;
    wait_cycles(3);

    // R2: load both bits, upper bits ignored
    bus_write(16'hFEEF, 8'h03);
    check("R2 tx set", {7'd0, line_tx}, 8'd1);
    check("R2 hs set", {7'd0, hs_out}, 8'd1);
    bus_write(16'hFEEF, 8'hFC);
    check("R2 upper bits ignored tx", {7'd0, line_tx}, 8'd0);
    check("R2 upper bits ignored hs", {7'd0, hs_out}, 8'd0);
    bus_write(16'hFEEF, 8'h02);
    check("R2 hs only", {6'd0, hs_out, line_tx}, 8'h02);

    // R1: near-miss addresses and missing iorq
    bus_write(16'hFEEE, 8'h01);
    check("R1 wrong address ignored", {6'd0, hs_out, line_tx}, 8'h02);
    bus_write(16'h7EEF, 8'h01);
    check("R1 high bit decoded", {6'd0, hs_out, line_tx}, 8'h02);
    bus_write(16'hFEEF, 8'h01, 1'b1);
    check("R1 no iorq ignored", {6'd0, hs_out, line_tx}, 8'h02);
    start_read(16'hFFEF);
    check("R1 read wrong address", rdata, 8'hFF);
    end_read();

    // R3: hold over idle cycles
    wait_cycles(5);
    check("R3 hold", {6'd0, hs_out, line_tx}, 8'h02);

    // R4: read format
    line_rx = 1'b1; hs_in_link = 1'b1;
    wait_cycles(3);
    start_read(16'hFEEF);
    check("R4 read all high", rdata, 8'hFE);
    check("R5 oe on read", {7'd0, rdata_oe}, 8'd1);
    end_read();
    line_rx = 1'b0; hs_in_link = 1'b0;
    wait_cycles(3);
    start_read(16'hFEEF);
    check("R4 read all low", rdata, 8'h3E);
    end_read();

    // R9: two-edge latency on the receive line, read held open
    start_read(16'hFEEF);
    line_rx = 1'b1;
    wait_cycles(1);
    check("R9 not yet after one edge", rdata, 8'h3E);
    wait_cycles(1);
    check("R9 seen after two edges", rdata, 8'hBE);
    end_read();

    // R8: jumper selects the handshake source
    hs_in_link = 1'b0; hs_in_prn = 1'b1; hs_pick = 1'b1;
    wait_cycles(3);
    start_read(16'hFEEF);
    check("R8 printer source", rdata, 8'hFE);
    hs_pick = 1'b0;
    #1;
    check("R8 link source", rdata, 8'hBE);
    end_read();

    // R6: switch off forces idle, ignores access
    bus_write(16'hFEEF, 8'h03);
    @(negedge clk); port_on = 1'b0;
    wait_cycles(1);
    check("R6 off forces idle", {6'd0, hs_out, line_tx}, 8'h00);
    bus_write(16'hFEEF, 8'h03);
    check("R6 write ignored while off", {6'd0, hs_out, line_tx}, 8'h00);
    start_read(16'hFEEF);
    check("R6 read undriven", rdata, 8'hFF);
    check("R5 oe low while off", {7'd0, rdata_oe}, 8'd0);
    end_read();
    @(negedge clk); port_on = 1'b1;
    wait_cycles(3);
    check("R6 stays idle after on", {6'd0, hs_out, line_tx}, 8'h00);

    // R7: asynchronous reset mid-run
    bus_write(16'hFEEF, 8'h03);
    @(negedge clk); #5 rst_n = 1'b0;
    #1;
    check("R7 async clear", {6'd0, hs_out, line_tx}, 8'h00);
    wait_cycles(2);
    rst_n = 1'b1;
    wait_cycles(3);

    finish_run();
  end
endmodule